// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the microsteps that take a 16-bit segmented processor into an interrupt or exception handler and back out again. It holds the instruction pointer, the code segment, the stack pointer and the flags word. Four kinds of event start it: a maskable request line, an edge-triggered non-maskable line, a software request that carries an 8-bit vector number, and a return-from-interrupt command. Divide errors and similar faults reach it as software requests with a fixed vector. The block does no fetching or decoding of its own.

On entry the block clears the interrupt-enable flag. It then pushes the flags word, CS and IP onto the stack at SS:SP. It reads the new IP and CS from a 4-byte entry in a vector table at the bottom of memory. A maskable request first runs an acknowledge cycle, in which the vector number is taken from the data bus. A return pops IP, CS and flags in that order.

The states are IDLE, ACK, PUSH_FL, PUSH_CS, PUSH_IP, LOAD_IP, LOAD_CS, POP_IP, POP_CS and POP_FL. The transitions are:
- IDLE to PUSH_FL on a non-maskable or software grant.
- IDLE to ACK on a maskable grant, then ACK to PUSH_FL.
- IDLE to POP_IP on a return grant.
- PUSH_FL to PUSH_CS to PUSH_IP to LOAD_IP to LOAD_CS, then back to IDLE.
- POP_IP to POP_CS to POP_FL, then back to IDLE.

Each state lasts one clock. Memory reads are combinational: read data is valid in the same cycle as the request.

Top module: `intr_seq`

## Requirements
- R1: After reset, ip_o, cs_o, sp_o and flags_o hold the values of the parameters RST_IP, RST_CS, RST_SP and RST_FLAGS. busy_o, mem_req and ack_o are all low.
- R2: The vector entry for number v sits at byte address 4*v. LOAD_IP reads the word at 4*v into IP, and LOAD_CS reads the word at 4*v+2 into CS.
- R3: Every entry clears the interrupt-enable flag (flags bit 9) when it is accepted. The flags word that is pushed therefore has bit 9 at 0 and every other bit unchanged.
- R4: Entry pushes flags, then CS, then IP. Before each write, SP drops by 2, and the word is written at physical address SS*16 + SP, modulo 2^20.
- R5: A maskable request is accepted only while flags bit 9 is 1. Its entry runs exactly one acknowledge cycle, with ack_o high, and the vector is taken from ack_vec in that cycle.
- R6: A rising edge on nmi_in is latched and serviced with vector 2, with no acknowledge cycle, whatever the state of flags bit 9.
- R7: A software request is serviced with the vector on sw_vec and with no acknowledge cycle.
- R8: A return reads IP, then CS, then flags, each at SS*16 + SP, and SP rises by 2 after each read.
- R9: busy_o is high for 5 cycles on a non-maskable or software entry, 6 cycles on a maskable entry and 3 cycles on a return. Requests that arrive while busy are held and serviced afterwards. When several are ready at once, the order of priority is non-maskable, then maskable, then software, then return.
- R10: In an idle cycle with no grant, ie_set_cmd sets flags bit 9 at the next edge. ie_clr_cmd clears it in the same way, and ie_set_cmd wins if both are high. Both commands are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_req | input | 1 | Maskable interrupt request (level) |
| nmi_in | input | 1 | Non-maskable request (rising edge) |
| sw_req | input | 1 | Software interrupt request pulse |
| sw_vec | input | 8 | Vector number of the software request |
| iret_cmd | input | 1 | Return-from-interrupt command pulse |
| ie_clr_cmd | input | 1 | Clear interrupt-enable command |
| ie_set_cmd | input | 1 | Set interrupt-enable command |
| ack_o | output | 1 | Acknowledge cycle strobe |
| ack_vec | input | 8 | Vector number on the data bus during acknowledge |
| ss_i | input | 16 | Stack segment |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the request cycle |
| ip_o | output | 16 | Instruction pointer |
| cs_o | output | 16 | Code segment |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 16 | Flags word, interrupt enable at bit 9 |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench sweeps all 256 vector numbers through software entry followed by a return. A mistake in the table address scaling, or IP and CS read from swapped halves of the entry, would show up as a wrong handler address for some vector. A pushed frame in the wrong order, or a stack pointer changed after the write instead of before it, would corrupt the logged write addresses or the restored context.

Two kinds of collision are exercised. A non-maskable edge that arrives together with a maskable request must win without an acknowledge cycle. A software request that arrives during another entry must run after it rather than be lost; a design that drops held requests would never enter the second handler. A maskable request with the enable flag cleared, and enable commands issued while busy, must change nothing on the ports.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_LOAD_IP,
        ST_LOAD_CS,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL
    } seq_state_e;
endpackage

// File: rtl/intr_req_hold.sv
module intr_req_hold #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_in,
    input  logic             sw_req,
    input  logic [VEC_W-1:0] sw_vec,
    input  logic             iret_cmd,
    input  logic             take_nmi,
    input  logic             take_sw,
    input  logic             take_iret,
    output logic             nmi_avail,
    output logic             sw_avail,
    output logic [VEC_W-1:0] sw_vec_eff,
    output logic             iret_avail
);
    logic             nmi_q, nmi_pend, sw_pend, iret_pend;
    logic [VEC_W-1:0] sw_vec_q;
    logic             nmi_rise;

    assign nmi_rise   = nmi_in && !nmi_q;
    assign nmi_avail  = nmi_pend || nmi_rise;
    assign sw_avail   = sw_pend || sw_req;
    assign sw_vec_eff = sw_req ? sw_vec : sw_vec_q;
    assign iret_avail = iret_pend || iret_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q     <= 1'b0;
            nmi_pend  <= 1'b0;
            sw_pend   <= 1'b0;
            iret_pend <= 1'b0;
            sw_vec_q  <= '0;
        end else begin
            nmi_q     <= nmi_in;
            nmi_pend  <= nmi_avail && !take_nmi;
            sw_pend   <= sw_avail && !take_sw;
            iret_pend <= iret_avail && !take_iret;
            if (sw_req) begin
                sw_vec_q <= sw_vec;
            end
        end
    end

    // R6: an edge that is not serviced at once stays available
    assert_nmi_edge_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && !nmi_q && !take_nmi) |=> nmi_avail);

    // R9: a software request that is not granted is kept
    assert_sw_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !take_sw) |=> sw_avail);
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter (
    input  logic idle,
    input  logic nmi_avail,
    input  logic mask_req,
    input  logic ie_flag,
    input  logic sw_avail,
    input  logic iret_avail,
    output logic g_nmi,
    output logic g_mask,
    output logic g_sw,
    output logic g_iret
);
    always_comb begin
        g_nmi  = 1'b0;
        g_mask = 1'b0;
        g_sw   = 1'b0;
        g_iret = 1'b0;
        if (idle) begin
            if (nmi_avail) begin
                g_nmi = 1'b1;
            end else if (mask_req && ie_flag) begin
                g_mask = 1'b1;
            end else if (sw_avail) begin
                g_sw = 1'b1;
            end else if (iret_avail) begin
                g_iret = 1'b1;
            end
        end
    end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 4
) (
    input  logic [WORD_W-1:0] seg,
    input  logic [WORD_W-1:0] off,
    output logic [ADDR_W-1:0] phys
);
    localparam int SHIFTED_W = WORD_W + SEG_SHIFT;

    logic [SHIFTED_W-1:0] seg_shifted;

    assign seg_shifted = {seg, {SEG_SHIFT{1'b0}}};
    assign phys = ADDR_W'(seg_shifted) + ADDR_W'(off);
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 4,
    parameter int IE_POS    = 9,
    parameter int NMI_VECTOR = 2,
    parameter logic [WORD_W-1:0] RST_IP    = '0,
    parameter logic [WORD_W-1:0] RST_CS    = '1,
    parameter logic [WORD_W-1:0] RST_SP    = '0,
    parameter logic [WORD_W-1:0] RST_FLAGS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_req,
    input  logic              nmi_in,
    input  logic              sw_req,
    input  logic [VEC_W-1:0]  sw_vec,
    input  logic              iret_cmd,
    input  logic              ie_clr_cmd,
    input  logic              ie_set_cmd,
    output logic              ack_o,
    input  logic [VEC_W-1:0]  ack_vec,
    input  logic [WORD_W-1:0] ss_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] ip_o,
    output logic [WORD_W-1:0] cs_o,
    output logic [WORD_W-1:0] sp_o,
    output logic [WORD_W-1:0] flags_o,
    output logic              busy_o
);
    localparam int STEP_BYTES = WORD_W / 8;
    localparam int ENTRY_SHIFT = 2;
    localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP_BYTES);
    localparam logic [ADDR_W-1:0] CS_OFFSET = ADDR_W'(STEP_BYTES);

    seq_state_e state_q, state_d;

    logic [WORD_W-1:0] ip_q, cs_q, sp_q, flags_q;
    logic [VEC_W-1:0]  vec_q;
    logic              nmi_avail, sw_avail, iret_avail;
    logic [VEC_W-1:0]  sw_vec_eff;
    logic              g_nmi, g_mask, g_sw, g_iret;
    logic              push_phase;
    logic [WORD_W-1:0] stk_off;
    logic [ADDR_W-1:0] stk_addr;
    logic [ADDR_W-1:0] vtab_base;

    intr_req_hold #(.VEC_W(VEC_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_in     (nmi_in),
        .sw_req     (sw_req),
        .sw_vec     (sw_vec),
        .iret_cmd   (iret_cmd),
        .take_nmi   (g_nmi),
        .take_sw    (g_sw),
        .take_iret  (g_iret),
        .nmi_avail  (nmi_avail),
        .sw_avail   (sw_avail),
        .sw_vec_eff (sw_vec_eff),
        .iret_avail (iret_avail)
    );

    intr_arbiter u_arb (
        .idle       (state_q == ST_IDLE),
        .nmi_avail  (nmi_avail),
        .mask_req   (mask_req),
        .ie_flag    (flags_q[IE_POS]),
        .sw_avail   (sw_avail),
        .iret_avail (iret_avail),
        .g_nmi      (g_nmi),
        .g_mask     (g_mask),
        .g_sw       (g_sw),
        .g_iret     (g_iret)
    );

    assign push_phase = (state_q == ST_PUSH_FL) || (state_q == ST_PUSH_CS) ||
                        (state_q == ST_PUSH_IP);
    assign stk_off    = push_phase ? (sp_q - STEP_W) : sp_q;
    assign vtab_base  = ADDR_W'({vec_q, {ENTRY_SHIFT{1'b0}}});

    seg_addr_calc #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_stk_addr (
        .seg  (ss_i),
        .off  (stk_off),
        .phys (stk_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (g_nmi || g_sw) begin
                    state_d = ST_PUSH_FL;
                end else if (g_mask) begin
                    state_d = ST_ACK;
                end else if (g_iret) begin
                    state_d = ST_POP_IP;
                end
            end
            ST_ACK:     state_d = ST_PUSH_FL;
            ST_PUSH_FL: state_d = ST_PUSH_CS;
            ST_PUSH_CS: state_d = ST_PUSH_IP;
            ST_PUSH_IP: state_d = ST_LOAD_IP;
            ST_LOAD_IP: state_d = ST_LOAD_CS;
            ST_LOAD_CS: state_d = ST_IDLE;
            ST_POP_IP:  state_d = ST_POP_CS;
            ST_POP_CS:  state_d = ST_POP_FL;
            ST_POP_FL:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = stk_addr;
        mem_wdata = '0;
        ack_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK:  ack_o = 1'b1;
            ST_PUSH_FL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = flags_q;
            end
            ST_PUSH_CS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = cs_q;
            end
            ST_PUSH_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ip_q;
            end
            ST_LOAD_IP: begin
                mem_req  = 1'b1;
                mem_addr = vtab_base;
            end
            ST_LOAD_CS: begin
                mem_req  = 1'b1;
                mem_addr = vtab_base + CS_OFFSET;
            end
            ST_POP_IP, ST_POP_CS, ST_POP_FL: mem_req = 1'b1;
            default: ;
        endcase
    end

    // architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_q    <= RST_IP;
            cs_q    <= RST_CS;
            sp_q    <= RST_SP;
            flags_q <= RST_FLAGS;
            vec_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (g_nmi) begin
                        vec_q           <= VEC_W'(NMI_VECTOR);
                        flags_q[IE_POS] <= 1'b0;
                    end else if (g_mask) begin
                        flags_q[IE_POS] <= 1'b0;
                    end else if (g_sw) begin
                        vec_q           <= sw_vec_eff;
                        flags_q[IE_POS] <= 1'b0;
                    end else if (!g_iret) begin
                        if (ie_set_cmd) begin
                            flags_q[IE_POS] <= 1'b1;
                        end else if (ie_clr_cmd) begin
                            flags_q[IE_POS] <= 1'b0;
                        end
                    end
                end
                ST_ACK: vec_q <= ack_vec;
                ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: sp_q <= sp_q - STEP_W;
                ST_LOAD_IP: ip_q <= mem_rdata;
                ST_LOAD_CS: cs_q <= mem_rdata;
                ST_POP_IP: begin
                    ip_q <= mem_rdata;
                    sp_q <= sp_q + STEP_W;
                end
                ST_POP_CS: begin
                    cs_q <= mem_rdata;
                    sp_q <= sp_q + STEP_W;
                end
                ST_POP_FL: begin
                    flags_q <= mem_rdata;
                    sp_q    <= sp_q + STEP_W;
                end
                default: ;
            endcase
        end
    end

    assign ip_o    = ip_q;
    assign cs_o    = cs_q;
    assign sp_o    = sp_q;
    assign flags_o = flags_q;
    assign busy_o  = (state_q != ST_IDLE);

    assert_ie_low_at_flag_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_FL) |-> !flags_q[IE_POS]);

    assert_push_predecrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (sp_q == $past(sp_q) - STEP_W));

    assert_pop_postincrement_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !(state_q == ST_LOAD_IP) && !(state_q == ST_LOAD_CS))
        |=> (sp_q == $past(sp_q) + STEP_W));

    assert_mask_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && state_d == ST_ACK) |-> flags_q[IE_POS]);

    assert_ack_then_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (state_q == ST_PUSH_FL && !ack_o));

    assert_vector_read_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD_IP) |-> (mem_req && !mem_we && mem_addr[ENTRY_SHIFT-1:0] == '0));

    assert_mem_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy_o);
endmodule

// File: tb/intr_seq_tb.sv
module intr_seq_tb;
    localparam logic [15:0] P_IP = 16'h1234;
    localparam logic [15:0] P_CS = 16'h5678;
    localparam logic [15:0] P_SP = 16'h0800;
    localparam logic [15:0] P_FL = 16'h02C5;
    localparam logic [15:0] SS_V = 16'h0100;
    localparam logic [15:0] IE_M = 16'h0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_req = 0, nmi_in = 0, sw_req = 0, iret_cmd = 0, ie_clr_cmd = 0, ie_set_cmd = 0;
    logic [7:0] sw_vec = '0, ack_vec = '0;
    logic ack_o, mem_req, mem_we, busy_o;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, ip_o, cs_o, sp_o, flags_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    intr_seq #(
        .RST_IP(P_IP), .RST_CS(P_CS), .RST_SP(P_SP), .RST_FLAGS(P_FL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mask_req(mask_req), .nmi_in(nmi_in),
        .sw_req(sw_req), .sw_vec(sw_vec), .iret_cmd(iret_cmd),
        .ie_clr_cmd(ie_clr_cmd), .ie_set_cmd(ie_set_cmd), .ack_o(ack_o),
        .ack_vec(ack_vec), .ss_i(SS_V), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ip_o(ip_o), .cs_o(cs_o), .sp_o(sp_o), .flags_o(flags_o), .busy_o(busy_o)
    );

    function automatic logic [15:0] vip(input logic [7:0] v);
        return 16'h4000 + 16'(v) * 16'd7;
    endfunction
    function automatic logic [15:0] vcs(input logic [7:0] v);
        return 16'hC003 ^ {v, ~v};
    endfunction

    // memory: vector table computed, stack region 0x1000..0x1FFF stored
    logic [15:0] stk [2048];
    logic [19:0] lg_a [16];
    logic [15:0] lg_d [16];
    int lg_n;
    logic tb_wr = 0;
    logic [10:0] tb_wa = '0;
    logic [15:0] tb_wd = '0;

    assign mem_rdata = (mem_addr < 20'h400) ?
        (mem_addr[1] ? vcs(mem_addr[9:2]) : vip(mem_addr[9:2])) : stk[mem_addr[11:1]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lg_n <= 0;
        end else if (mem_req && mem_we) begin
            lg_a[lg_n % 16] <= mem_addr;
            lg_d[lg_n % 16] <= mem_wdata;
            stk[mem_addr[11:1]] <= mem_wdata;
            lg_n <= lg_n + 1;
        end else if (tb_wr) begin
            stk[tb_wa] <= tb_wd;
        end
    end

    logic [15:0] m_ip, m_cs, m_sp, m_fl;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // waits for one busy period; pulse inputs drop after the first edge
    task automatic wait_op(output int nb, output int na);
        int cyc = 0;
        bit seen = 0;
        nb = 0;
        na = 0;
        do begin
            @(negedge clk);
            sw_req = 0; iret_cmd = 0; nmi_in = 0; ie_set_cmd = 0; ie_clr_cmd = 0;
            if (busy_o) begin seen = 1; nb++; end
            if (ack_o) na++;
            cyc++;
        end while ((!seen || busy_o) && cyc < 60);
        if (cyc >= 60) chk("R9 operation timeout", 1, 0);
    endtask

    task automatic chk_ports(input string tag);
        chk({tag, " ip"}, ip_o, m_ip);
        chk({tag, " cs"}, cs_o, m_cs);
        chk({tag, " sp"}, sp_o, m_sp);
        chk({tag, " flags"}, flags_o, m_fl);
    endtask

    // R2 R3 R4: frame written at logged index base, then handler loaded
    task automatic model_entry(input string tag, input logic [7:0] v, input int base);
        logic [15:0] fl_push;
        fl_push = m_fl & ~IE_M;
        chk({tag, " R4 flags addr"}, lg_a[base % 16], 20'h01000 + 20'(m_sp - 16'd2));
        chk({tag, " R3 pushed flags"}, lg_d[base % 16], fl_push);
        chk({tag, " R4 cs addr"}, lg_a[(base + 1) % 16], 20'h01000 + 20'(m_sp - 16'd4));
        chk({tag, " R4 cs data"}, lg_d[(base + 1) % 16], m_cs);
        chk({tag, " R4 ip addr"}, lg_a[(base + 2) % 16], 20'h01000 + 20'(m_sp - 16'd6));
        chk({tag, " R4 ip data"}, lg_d[(base + 2) % 16], m_ip);
        m_fl = fl_push;
        m_sp = m_sp - 16'd6;
        m_ip = vip(v);
        m_cs = vcs(v);
        chk_ports({tag, " R2"});
    endtask

    task automatic do_iret(input string tag);
        int nb, na;
        logic [15:0] e_ip, e_cs, e_fl;
        e_ip = stk[m_sp[11:1]];
        e_cs = stk[11'(m_sp[11:1] + 11'd1)];
        e_fl = stk[11'(m_sp[11:1] + 11'd2)];
        iret_cmd = 1;
        wait_op(nb, na);
        m_ip = e_ip; m_cs = e_cs; m_fl = e_fl; m_sp = m_sp + 16'd6;
        chk_ports({tag, " R8 return"});
        chk({tag, " R9 return busy cycles"}, nb, 3);
    endtask

    task automatic set_ie();
        @(negedge clk);
        ie_set_cmd = 1;
        @(negedge clk);
        ie_set_cmd = 0;
        m_fl = m_fl | IE_M;
        chk("R10 set enable", flags_o, m_fl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nb, na, base;
        m_ip = P_IP; m_cs = P_CS; m_sp = P_SP; m_fl = P_FL;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 ack", ack_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk_ports("R1 reset");

        // R7 sweep of every vector through software entry and return
        for (int v = 0; v < 256; v++) begin
            if (m_fl[9] == 1'b0) set_ie();
            base = lg_n;
            sw_req = 1; sw_vec = 8'(v);
            wait_op(nb, na);
            model_entry("R7 sw", 8'(v), base);
            chk("R9 sw busy cycles", nb, 5);
            chk("R7 no ack", na, 0);
            do_iret("sweep");
        end

        // R5 maskable entries with acknowledge vector
        for (int v = 3; v < 256; v += 37) begin
            set_ie();
            base = lg_n;
            mask_req = 1; ack_vec = 8'(v);
            wait_op(nb, na);
            mask_req = 0;
            model_entry("R5 mask", 8'(v), base);
            chk("R9 mask busy cycles", nb, 6);
            chk("R5 one ack", na, 1);
            do_iret("mask");
        end

        // R6 nmi beats maskable; R9 software held behind it
        set_ie();
        base = lg_n;
        mask_req = 1; nmi_in = 1; sw_req = 1; sw_vec = 8'h5A; ack_vec = 8'h77;
        wait_op(nb, na);
        model_entry("R6 nmi", 8'd2, base);
        chk("R6 nmi no ack", na, 0);
        chk("R6 nmi busy cycles", nb, 5);
        wait_op(nb, na);
        model_entry("R9 held sw", 8'h5A, base + 3);
        chk("R9 held sw no ack", na, 0);
        mask_req = 0;
        do_iret("nested1");
        do_iret("nested2");

        // R6 nmi with enable clear
        @(negedge clk);
        ie_clr_cmd = 1;
        @(negedge clk);
        ie_clr_cmd = 0;
        m_fl = m_fl & ~IE_M;
        chk("R10 clear enable", flags_o, m_fl);
        base = lg_n;
        nmi_in = 1;
        wait_op(nb, na);
        model_entry("R6 nmi ie off", 8'd2, base);
        do_iret("nmi2");

        // R5 maskable ignored while enable is clear
        mask_req = 1; ack_vec = 8'h10;
        nb = 0; na = 0;
        repeat (8) begin
            @(negedge clk);
            if (busy_o) nb++;
            if (ack_o) na++;
        end
        mask_req = 0;
        chk("R5 masked no busy", nb, 0);
        chk("R5 masked no ack", na, 0);
        chk_ports("R5 masked no change");

        // R10 enable set ignored while busy
        base = lg_n;
        sw_req = 1; sw_vec = 8'h21;
        @(negedge clk);
        sw_req = 0;
        ie_set_cmd = 1;
        wait_op(nb, na);
        model_entry("R10 set while busy", 8'h21, base);
        chk("R10 enable stays clear", flags_o[9], 0);
        do_iret("busyset");

        // R8 return from a hand-built frame
        tb_wa = m_sp[11:1]; tb_wd = 16'hBEEF; tb_wr = 1;
        @(negedge clk);
        tb_wa = 11'(m_sp[11:1] + 11'd1); tb_wd = 16'hCAFE;
        @(negedge clk);
        tb_wa = 11'(m_sp[11:1] + 11'd2); tb_wd = 16'h0A55;
        @(negedge clk);
        tb_wr = 0;
        do_iret("R8 frame");
        chk("R8 frame flags", flags_o, 16'h0A55);

        // R9 maskable beats software when both ready
        base = lg_n;
        mask_req = 1; ack_vec = 8'h33; sw_req = 1; sw_vec = 8'h44;
        wait_op(nb, na);
        mask_req = 0;
        model_entry("R9 mask first", 8'h33, base);
        chk("R9 mask first ack", na, 1);
        wait_op(nb, na);
        model_entry("R9 sw second", 8'h44, base + 3);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule